// File: doc/BRIEF.md
# Front-Panel Setting Controller for a Multi-Channel Discriminator

This controller turns three operator inputs into the settings of a bank of discriminator channels. A three-way parameter selector chooses what is edited: the per-channel threshold, the per-group output width or the per-group dead time. A two-position switch is either in its lock position, which freezes every setting, or in its edit position. In the edit position each select strobe moves to the next target. A rotary encoder delivers up and down strobes that change the value of the current target.

Each channel holds a threshold code with 257 states: the values 0 to 255 and an extra inhibit state that disables the channel. Channels are split into groups, and each group holds an 8-bit width code and an 8-bit dead-time code. The settings are kept in a working register file, which is loaded at reset from a non-volatile image. Any out-of-range code in that image is replaced by the mid-scale value 128. The controller drives one indicator LED per channel, plus a display status code and value, so an operator can see what is being edited.

Threshold selection steps through every channel and then a broadcast slot. A value edited in the broadcast slot reaches the channels only when the switch returns to lock. Moving on without locking drops that value.

Top module: `panel_prog_ctrl`

## Requirements
- R1: At reset, each setting loads from its non-volatile input. A threshold image above 256, or a width or dead-time image above 255, loads as 128 instead. The switch is sampled as locked, so leaving reset never triggers a broadcast commit.
- R2: The selector code is decoded as 0 = threshold, 1 = width, 2 = dead time; code 3 acts exactly like 0. In threshold mode, with the switch unlocked, position k (0 to NCH-1) lights only LED k. The next select strobe reaches the broadcast slot and lights all LEDs. The strobe after that returns to channel 0.
- R3: A threshold code is stored as a 9-bit value, where 256 means inhibit. An up step goes 255 → 256 → 0 → 1. A down step runs the same cycle in reverse. The display code is 1 for a plain value, 2 for inhibit (display value 0), and 0 while locked (display value 0).
- R4: An encoder step at a channel position rewrites that channel's threshold on the next clock edge. All other channels keep their values.
- R5: Entering the broadcast slot loads its pending value from channel 0. Encoder steps change only this pending value. Moving the switch to lock while still in the slot writes the pending value to every channel. Moving on with a select strobe leaves all channels untouched.
- R6: Channel c belongs to group (c/2) mod NGRP. In width and dead-time modes, the LEDs of every channel in the selected group are lit. Select strobes cycle through groups 0 to NGRP-1. Encoder steps wrap 255 ↔ 0 in both directions.
- R7: While locked, the LEDs show exactly the inhibited channels. Select and encoder strobes change no setting and no LED.
- R8: A change of the decoded selector mode returns the position to channel 0 or group 0 and drops any pending broadcast value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| param_sel | input | 2 | Parameter selector code |
| lock | input | 1 | 1 = switch in lock position |
| sel_step | input | 1 | One-cycle select strobe |
| enc_up | input | 1 | One-cycle encoder increment strobe |
| enc_dn | input | 1 | One-cycle encoder decrement strobe |
| nv_thr | input | NCH*9 | Stored threshold image, channel c at bits 9c+8:9c |
| nv_width | input | NGRP*9 | Stored width image, group g at bits 9g+8:9g |
| nv_dead | input | NGRP*9 | Stored dead-time image, group g at bits 9g+8:9g |
| led | output | NCH | Channel indicator LEDs |
| disp_code | output | 2 | 0 locked, 1 value, 2 inhibit |
| disp_val | output | 8 | Value of the current target |
| thr_q | output | NCH*9 | Working thresholds, channel c at bits 9c+8:9c |
| width_q | output | NGRP*8 | Working widths, group g at bits 8g+7:8g |
| dead_q | output | NGRP*8 | Working dead times, group g at bits 8g+7:8g |

## Verification
The bench builds the block with NCH = 8 and NGRP = 2. Eight channels keep a full sweep through the broadcast slot short enough to repeat, so both the discard path and the commit path are exercised. Two groups make the interleaved membership visible on the LEDs as the 0x33 and 0xCC patterns, and they show the group wrap after a single extra strobe. The reset image mixes valid, inhibit and out-of-range codes, so the mid-scale substitution is checked on thresholds, widths and dead times alike.

// File: rtl/panel_prog_ctrl.sv
`timescale 1ns/1ps
module panel_prog_ctrl #(
  parameter int NCH  = 16,
  parameter int NGRP = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          param_sel,
  input  logic                lock,
  input  logic                sel_step,
  input  logic                enc_up,
  input  logic                enc_dn,
  input  logic [NCH*9-1:0]    nv_thr,
  input  logic [NGRP*9-1:0]   nv_width,
  input  logic [NGRP*9-1:0]   nv_dead,
  output logic [NCH-1:0]      led,
  output logic [1:0]          disp_code,
  output logic [7:0]          disp_val,
  output logic [NCH*9-1:0]    thr_q,
  output logic [NGRP*8-1:0]   width_q,
  output logic [NGRP*8-1:0]   dead_q
);
  localparam int PW = $clog2(NCH + 1);
  localparam int CW = $clog2(NCH);
  localparam int GW = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam logic [PW-1:0] ALL = PW'(NCH);
  localparam logic [PW-1:0] GLAST = PW'(NGRP - 1);
  localparam logic [8:0] INH = 9'd256;
  localparam logic [8:0] MID = 9'd128;
  localparam logic [1:0] M_THR = 2'd0, M_WID = 2'd1;

  logic [8:0]    thr [NCH];
  logic [7:0]    wdt [NGRP];
  logic [7:0]    ddt [NGRP];
  logic [PW-1:0] idx;
  logic [8:0]    all_val;
  logic          lock_q;
  logic [1:0]    mode_q;
  logic [8:0]    cur;

  wire [1:0]    mode = (param_sel == 2'd3) ? M_THR : param_sel;
  wire [CW-1:0] cidx = idx[CW-1:0];
  wire [GW-1:0] gidx = idx[GW-1:0];
  wire          step = enc_up ^ enc_dn;

  function automatic logic [8:0] next_thr(input logic [8:0] v, input logic up);
    if (up) return (v >= INH) ? 9'd0 : v + 9'd1;
    return (v == 9'd0) ? INH : v - 9'd1;
  endfunction

  function automatic logic [7:0] next_byte(input logic [7:0] v, input logic up);
    return up ? v + 8'd1 : v - 8'd1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++)
        thr[c] <= (nv_thr[c*9 +: 9] > INH) ? MID : nv_thr[c*9 +: 9];
      for (int g = 0; g < NGRP; g++) begin
        wdt[g] <= (nv_width[g*9 +: 9] > 9'd255) ? MID[7:0] : nv_width[g*9 +: 8];
        ddt[g] <= (nv_dead[g*9 +: 9] > 9'd255) ? MID[7:0] : nv_dead[g*9 +: 8];
      end
      idx     <= '0;
      all_val <= '0;
      lock_q  <= 1'b1;
      mode_q  <= mode;
    end else begin
      lock_q <= lock;
      mode_q <= mode;
      if (mode != mode_q) begin
        idx <= '0;
      end else if (!lock) begin
        if (sel_step) begin
          if (mode == M_THR) begin
            idx <= (idx == ALL) ? '0 : idx + 1'b1;
            if (idx == ALL - 1'b1) all_val <= thr[0];
          end else begin
            idx <= (idx >= GLAST) ? '0 : idx + 1'b1;
          end
        end else if (step) begin
          case (mode)
            M_THR:   if (idx == ALL) all_val <= next_thr(all_val, enc_up);
                     else thr[cidx] <= next_thr(thr[cidx], enc_up);
            M_WID:   wdt[gidx] <= next_byte(wdt[gidx], enc_up);
            default: ddt[gidx] <= next_byte(ddt[gidx], enc_up);
          endcase
        end
      end
      if (lock && !lock_q && mode == M_THR && idx == ALL)
        for (int c = 0; c < NCH; c++) thr[c] <= all_val;
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      if (lock)               led[c] = (thr[c] == INH);
      else if (mode == M_THR) led[c] = (idx == ALL) || (idx == PW'(c));
      else                    led[c] = (idx == PW'((c / 2) % NGRP));
    end
  end

  always_comb begin
    if (mode == M_THR)      cur = (idx == ALL) ? all_val : thr[cidx];
    else if (mode == M_WID) cur = {1'b0, wdt[gidx]};
    else                    cur = {1'b0, ddt[gidx]};
  end

  assign disp_code = lock ? 2'd0 : (cur == INH) ? 2'd2 : 2'd1;
  assign disp_val  = lock ? 8'd0 : cur[7:0];

  for (genvar c = 0; c < NCH; c++) begin : g_thr_out
    assign thr_q[c*9 +: 9] = thr[c];
  end
  for (genvar g = 0; g < NGRP; g++) begin : g_grp_out
    assign width_q[g*8 +: 8] = wdt[g];
    assign dead_q[g*8 +: 8]  = ddt[g];
  end
endmodule

// File: rtl/panel_prog_ctrl_chk.sv
`timescale 1ns/1ps
module panel_prog_ctrl_chk #(
  parameter int NCH  = 16,
  parameter int NGRP = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        param_sel,
  input logic              lock,
  input logic [NCH-1:0]    led,
  input logic [NCH*9-1:0]  thr_q,
  input logic [NGRP*8-1:0] width_q,
  input logic [NGRP*8-1:0] dead_q
);
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    lock && $past(lock) && $past(lock, 2) |-> $stable(thr_q) && $stable(width_q) && $stable(dead_q)); // R7

  AST_THR_SINGLE_LED: assert property (@(posedge clk) disable iff (!rst_n)
    !lock && (param_sel == 2'd0 || param_sel == 2'd3) && led != '1 |-> $countones(led) == 1); // R2

  AST_MODE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    param_sel == 2'd1 && $past(param_sel) != 2'd1 |=> lock || param_sel != 2'd1 || led[0]); // R8

  for (genvar c = 0; c < NCH; c++) begin : g_rng
    AST_THR_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      thr_q[c*9 +: 9] <= 9'd256); // R3
  end
endmodule

bind panel_prog_ctrl panel_prog_ctrl_chk #(.NCH(NCH), .NGRP(NGRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .param_sel(param_sel), .lock(lock), .led(led),
  .thr_q(thr_q), .width_q(width_q), .dead_q(dead_q));

// File: tb/tb_panel_prog_ctrl.sv
`timescale 1ns/1ps
module tb_panel_prog_ctrl;
  localparam int NCH = 8;
  localparam int NGRP = 2;

  logic clk = 0, rst_n = 0, lock = 1, sel_step = 0, enc_up = 0, enc_dn = 0;
  logic [1:0] param_sel = 2'd0;
  logic [NCH*9-1:0] nv_thr;
  logic [NGRP*9-1:0] nv_width, nv_dead;
  logic [NCH-1:0] led;
  logic [1:0] disp_code;
  logic [7:0] disp_val;
  logic [NCH*9-1:0] thr_q;
  logic [NGRP*8-1:0] width_q, dead_q;
  int checks = 0, errors = 0;
  bit done = 0;

  panel_prog_ctrl #(.NCH(NCH), .NGRP(NGRP)) dut (.*);

  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int thr(input int c);
    return int'(thr_q[c*9 +: 9]);
  endfunction

  task automatic strobe(input int which);
    @(negedge clk);
    sel_step = (which == 0); enc_up = (which == 1); enc_dn = (which == 2);
    @(negedge clk);
    sel_step = 0; enc_up = 0; enc_dn = 0;
    #1;
  endtask

  task automatic set_lock(input logic v);
    @(negedge clk); lock = v; @(negedge clk); #1;
  endtask

  task automatic set_param(input logic [1:0] v);
    @(negedge clk); param_sel = v; @(negedge clk); #1;
  endtask

  task automatic t_reset;
    int exp_thr[NCH] = '{1, 11, 21, 128, 41, 256, 61, 71};
    for (int c = 0; c < NCH; c++) check("R1 thr", thr(c), exp_thr[c]);
    check("R1 width g0", int'(width_q[7:0]), 40);
    check("R1 width g1", int'(width_q[15:8]), 128);
    check("R1 dead g0", int'(dead_q[7:0]), 128);
    check("R1 dead g1", int'(dead_q[15:8]), 7);
    check("R7 locked led", int'(led), 'h20);
    check("R3 locked code", int'(disp_code), 0);
  endtask

  task automatic t_thr_walk;
    set_lock(0);
    check("R2 first led", int'(led), 1);
    check("R3 value code", int'(disp_code), 1);
    check("R2 first value", int'(disp_val), 1);
    for (int k = 1; k < NCH; k++) begin
      strobe(0);
      check("R2 walk led", int'(led), 1 << k);
    end
    strobe(0);
    check("R2 all slot led", int'(led), 'hFF);
    check("R5 slot preload", int'(disp_val), 1);
    strobe(0);
    check("R2 wrap led", int'(led), 1);
  endtask

  task automatic t_thr_enc;
    strobe(2); check("R4 ch0 down", thr(0), 0);
    check("R3 disp 0", int'(disp_val), 0);
    strobe(2); check("R3 down to inhibit", thr(0), 256);
    check("R3 inhibit code", int'(disp_code), 2);
    strobe(2); check("R3 inhibit down", thr(0), 255);
    check("R3 disp 255", int'(disp_val), 255);
    strobe(1); check("R3 255 up", thr(0), 256);
    strobe(1); check("R3 inhibit up", thr(0), 0);
    strobe(1); check("R3 0 up", thr(0), 1);
    check("R4 ch1 untouched", thr(1), 11);
  endtask

  task automatic t_broadcast;
    for (int k = 0; k < NCH; k++) strobe(0);
    check("R5 slot led", int'(led), 'hFF);
    for (int k = 0; k < 3; k++) strobe(1);
    check("R5 pending value", int'(disp_val), 4);
    check("R5 ch0 before leave", thr(0), 1);
    strobe(0);
    check("R5 discard led", int'(led), 1);
    check("R5 discard ch0", thr(0), 1);
    check("R5 discard ch1", thr(1), 11);
    check("R5 discard ch7", thr(7), 71);
    for (int k = 0; k < NCH; k++) strobe(0);
    check("R5 reload value", int'(disp_val), 1);
    strobe(2); strobe(2);
    check("R5 pending inhibit", int'(disp_code), 2);
    set_lock(1);
    for (int c = 0; c < NCH; c++) check("R5 committed", thr(c), 256);
    check("R7 all inhibited leds", int'(led), 'hFF);
    check("R3 lock code", int'(disp_code), 0);
  endtask

  task automatic t_lock_ignore;
    strobe(1); strobe(0); strobe(2);
    for (int c = 0; c < NCH; c++) check("R7 thr frozen", thr(c), 256);
    check("R7 led frozen", int'(led), 'hFF);
    set_param(1);
    strobe(1);
    check("R7 width frozen", int'(width_q[7:0]), 40);
    set_lock(0);
    check("R6 group0 leds", int'(led), 'h33);
    check("R6 width value", int'(disp_val), 40);
  endtask

  task automatic t_groups;
    strobe(2); check("R6 width down", int'(width_q[7:0]), 39);
    strobe(0); check("R6 group1 leds", int'(led), 'hCC);
    check("R6 group1 width", int'(disp_val), 128);
    strobe(0); check("R6 group wrap", int'(led), 'h33);
    set_param(2);
    check("R6 dead g0 value", int'(disp_val), 128);
    strobe(0); check("R6 dead g1 led", int'(led), 'hCC);
    check("R6 dead g1 value", int'(disp_val), 7);
    for (int k = 0; k < 7; k++) strobe(2);
    check("R6 dead at zero", int'(dead_q[15:8]), 0);
    strobe(2); check("R6 wrap 0 to 255", int'(dead_q[15:8]), 255);
    strobe(1); check("R6 wrap 255 to 0", int'(dead_q[15:8]), 0);
    check("R6 other group kept", int'(dead_q[7:0]), 128);
  endtask

  task automatic t_mode_change;
    set_param(1);
    check("R8 restart group0", int'(led), 'h33);
    strobe(0);
    check("R8 moved", int'(led), 'hCC);
    set_param(3);
    check("R8 restart ch0", int'(led), 1);
    check("R2 code3 is threshold", int'(disp_code), 2);
    strobe(0);
    set_param(0);
    check("R2 code3 equals code0", int'(led), 2);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) nv_thr[c*9 +: 9] = 9'(c * 10 + 1);
    nv_thr[3*9 +: 9] = 9'd300;
    nv_thr[5*9 +: 9] = 9'd256;
    nv_width = {9'd400, 9'd40};
    nv_dead  = {9'd7, 9'd300};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_thr_walk();
    t_thr_enc();
    t_broadcast();
    t_lock_ignore();
    t_groups();
    t_mode_change();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule